// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Recognition

This block receives asynchronous serial frames on a single line, `rxd`, which it samples on a free-running oversampling tick at sixteen ticks per bit. A frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then one stop bit. The `nine_bit` input picks the data length, and the block latches that choice when it accepts a start bit. The three ticks at the centre of each bit are combined by majority vote. Any disagreement among those three samples is recorded as noise.

A finished frame lands in a single holding register. `rx_full` serves as the valid signal for that register, and a one-cycle pulse on `rd_strobe` serves as the ready/pop. The line cannot be stalled, so back-pressure is never applied to it. If a frame completes while the register is still full, that frame is discarded and `overrun` is raised.

A frame whose data bits are all zero and whose stop bit is also zero counts as a line break. A break is posted as a full register that holds zero and carries the framing-error flag. A non-zero frame with a bad stop bit keeps its data and also raises the framing-error flag. Parity and address wakeup are not part of this block.

Top module: `sci_rx_break`

## Requirements
- R1: After reset, `rx_full`, `frame_err`, `overrun` and `noise_err` are 0 and `rx_data` is all zeros.
- R2: With `nine_bit`=0, a frame with a valid stop bit sets `rx_full`, clears `frame_err`, and presents its 8 data bits (the first one received is bit 0) in `rx_data[7:0]`, with `rx_data[8]`=0.
- R3: With `nine_bit`=1, all 9 data bits are captured into `rx_data[8:0]`, with the first one received in bit 0.
- R4: A frame whose stop bit samples as 0 and whose data is non-zero sets `frame_err` and `rx_full`, and keeps the received data in `rx_data`.
- R5: A break is a start bit, then 8 (or 9 when `nine_bit`=1) zero data bits, then a 0 in the stop position. Receiving one sets `rx_full` and `frame_err` and sets `rx_data` to all zeros.
- R6: If a frame completes while `rx_full` is 1 and no read occurs in that cycle, `overrun` is set, and `rx_data`, `frame_err` and `noise_err` keep their values.
- R7: A one-cycle pulse on `rd_strobe` clears `rx_full`, `frame_err`, `overrun` and `noise_err`.
- R8: Each bit is sampled on ticks 7, 8 and 9 of its 16 and resolved by majority. If one sample disagrees, the bit still takes the majority value, and `noise_err` is set when the frame is accepted.
- R9: If the start bit reads high by majority at its centre, it is a false start. No frame is posted, and the receiver goes back to hunting for a falling line.
- R10: A break that completes while `rx_full` is 1 follows the overrun rule. `overrun` is set, and the held data and `frame_err` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line; idles high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| rd_strobe | input | 1 | Pop pulse: consumes the held word and clears the flags |
| rx_data | output | 9 | Received word (all zeros after a break) |
| rx_full | output | 1 | Holding register contains an unread word |
| frame_err | output | 1 | Stop bit sampled as 0 |
| overrun | output | 1 | A frame was dropped because the register was full |
| noise_err | output | 1 | At least one bit of the accepted frame had disagreeing samples |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a centre at tick 8, 9 data bits at most, and a two-stage line synchroniser. It drives `os_tick` once every four clocks. Because of this, every line change the bench makes reaches the voter exactly one tick later. That exactness lets the bench invert one chosen sample in the centre of one bit, so it can exercise the noise vote without changing the majority. It can also place a start pulse short enough to be rejected at its centre, and it can time a second frame or a break so that it completes while the register is still full.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/sci_rx_sync.sv
module sci_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sci_rx_vote.sv
module sci_rx_vote #(
  parameter int OSR = 16,
  parameter int MID = 8,
  localparam int CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          rx,
  output logic          bit_ready,
  output logic          bit_val,
  output logic          bit_noisy
);
  logic s_early, s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      if (cnt == CW'(MID - 1)) s_early <= rx;
      if (cnt == CW'(MID))     s_mid   <= rx;
    end
  end

  always_comb begin
    bit_ready = tick && (cnt == CW'(MID + 1));
    bit_val   = (s_early & s_mid) | (s_early & rx) | (s_mid & rx);
    bit_noisy = !((s_early == s_mid) && (s_mid == rx));
  end
endmodule

// File: rtl/sci_rx_framer.sv
module sci_rx_framer
  import sci_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 9,
  localparam int CW = $clog2(OSR),
  localparam int IW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              nine_bit,
  input  logic              bit_ready,
  input  logic              bit_val,
  input  logic              bit_noisy,
  output logic [CW-1:0]     cnt,
  output logic              frame_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_stop,
  output logic              frm_noisy
);
  rx_state_e         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              mode_q;
  logic              noise_acc;
  logic [IW-1:0]     last_idx;

  assign last_idx = mode_q ? IW'(DATA_W - 1) : IW'(DATA_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      mode_q     <= 1'b0;
      noise_acc  <= 1'b0;
      frame_done <= 1'b0;
      frm_data   <= '0;
      frm_stop   <= 1'b1;
      frm_noisy  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        if (state == ST_HUNT) begin
          if (!rx) begin
            state     <= ST_START;
            cnt       <= CW'(1);
            mode_q    <= nine_bit;
            noise_acc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + CW'(1);
          if (bit_ready) begin
            unique case (state)
              ST_START: begin
                if (bit_val) state <= ST_HUNT;
                else begin
                  state     <= ST_DATA;
                  idx       <= '0;
                  noise_acc <= bit_noisy;
                end
              end
              ST_DATA: begin
                shreg     <= {bit_val, shreg[DATA_W-1:1]};
                noise_acc <= noise_acc | bit_noisy;
                idx       <= idx + IW'(1);
                if (idx == last_idx) state <= ST_STOP;
              end
              ST_STOP: begin
                frame_done <= 1'b1;
                frm_stop   <= bit_val;
                frm_noisy  <= noise_acc | bit_noisy;
                frm_data   <= mode_q ? shreg : (shreg >> 1);
                state      <= ST_HUNT;
              end
              default: state <= ST_HUNT;
            endcase
          end
        end
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && bit_ready && bit_val) |=> (state == ST_HUNT && !frame_done));
endmodule

// File: rtl/sci_rx_flags.sv
module sci_rx_flags #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_stop,
  input  logic              frm_noisy,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              fe_q,
  output logic              ovr_q,
  output logic              nf_q
);
  logic is_break;
  logic blocked;

  assign is_break = (frm_data == '0) && !frm_stop;
  assign blocked  = full_q && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      nf_q   <= 1'b0;
    end else begin
      if (rd) begin
        full_q <= 1'b0;
        fe_q   <= 1'b0;
        ovr_q  <= 1'b0;
        nf_q   <= 1'b0;
      end
      if (frame_done) begin
        if (blocked) ovr_q <= 1'b1;
        else begin
          data_q <= is_break ? '0 : frm_data;
          full_q <= 1'b1;
          fe_q   <= !frm_stop;
          nf_q   <= frm_noisy;
        end
      end
    end
  end

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && full_q && !rd) |=> (ovr_q && data_q == $past(data_q) && fe_q == $past(fe_q)));

  // R6
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !frame_done) |=> !(full_q || fe_q || ovr_q || nf_q));

  // R5
  break_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !(full_q && !rd) && frm_data == '0 && !frm_stop)
      |=> (full_q && fe_q && data_q == '0));
endmodule

// File: rtl/sci_rx_break.sv
module sci_rx_break #(
  parameter int OSR         = 16,
  parameter int MID         = 8,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              nine_bit,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun,
  output logic              noise_err
);
  logic              rx_s;
  logic [CW-1:0]     cnt;
  logic              bit_ready, bit_val, bit_noisy;
  logic              frame_done, frm_stop, frm_noisy;
  logic [DATA_W-1:0] frm_data;

  sci_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  sci_rx_vote #(.OSR(OSR), .MID(MID)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .cnt(cnt), .rx(rx_s),
    .bit_ready(bit_ready), .bit_val(bit_val), .bit_noisy(bit_noisy)
  );

  sci_rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .nine_bit(nine_bit),
    .bit_ready(bit_ready), .bit_val(bit_val), .bit_noisy(bit_noisy),
    .cnt(cnt), .frame_done(frame_done), .frm_data(frm_data),
    .frm_stop(frm_stop), .frm_noisy(frm_noisy)
  );

  sci_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frm_data(frm_data),
    .frm_stop(frm_stop), .frm_noisy(frm_noisy), .rd(rd_strobe),
    .data_q(rx_data), .full_q(rx_full), .fe_q(frame_err),
    .ovr_q(overrun), .nf_q(noise_err)
  );
endmodule

// File: tb/sci_rx_break_tb.sv
module sci_rx_break_tb;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic       nine_bit = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, frame_err, overrun, noise_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sci_rx_break u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .nine_bit(nine_bit), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun),
    .noise_err(noise_err)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [8:0] d, input bit f, input bit fe,
                           input bit ov, input bit nf);
    chk(rx_data === d, {req, " data"}, 16'(rx_data), 16'(d));
    chk(rx_full === f, {req, " full"}, 16'(rx_full), 16'(f));
    chk(frame_err === fe, {req, " frame_err"}, 16'(frame_err), 16'(fe));
    chk(overrun === ov, {req, " overrun"}, 16'(overrun), 16'(ov));
    chk(noise_err === nf, {req, " noise"}, 16'(noise_err), 16'(nf));
  endtask

  task automatic slot(input bit v);
    @(negedge clk); rxd = v; os_tick = 1'b1;
    @(negedge clk); os_tick = 1'b0;
    repeat (TDIV - 2) @(negedge clk);
  endtask

  // glitch_idx: 0 = start, 1..n = data bits, n+1 = stop; -1 for none
  task automatic send_frame(input logic [8:0] d, input bit nine, input bit stop, input int glitch_idx);
    int n;
    nine_bit = nine;
    n = nine ? 9 : 8;
    for (int b = 0; b < n + 2; b++) begin
      bit v;
      v = (b == 0) ? 1'b0 : (b == n + 1) ? stop : d[b-1];
      for (int o = 0; o < 16; o++) slot((b == glitch_idx && o == 8) ? ~v : v);
    end
    for (int i = 0; i < 24; i++) slot(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R1", 9'h000, 0, 0, 0, 0);
  endtask

  task automatic t_basic8();
    send_frame(9'h0A5, 0, 1, -1);
    chk_state("R2", 9'h0A5, 1, 0, 0, 0);
    do_read();
    chk_state("R7", 9'h0A5, 0, 0, 0, 0);
  endtask

  task automatic t_nine();
    send_frame(9'h1C3, 1, 1, -1);
    chk_state("R3", 9'h1C3, 1, 0, 0, 0);
    do_read();
  endtask

  task automatic t_ferr();
    send_frame(9'h03C, 0, 0, -1);
    chk_state("R4", 9'h03C, 1, 1, 0, 0);
    do_read();
    chk_state("R7", 9'h03C, 0, 0, 0, 0);
  endtask

  task automatic t_break8();
    send_frame(9'h000, 0, 0, -1);
    chk_state("R5", 9'h000, 1, 1, 0, 0);
    do_read();
  endtask

  task automatic t_break9();
    send_frame(9'h155, 1, 1, -1);
    do_read();
    send_frame(9'h000, 1, 0, -1);
    chk_state("R5", 9'h000, 1, 1, 0, 0);
    do_read();
  endtask

  task automatic t_noise();
    send_frame(9'h05A, 0, 1, 4);
    chk_state("R8", 9'h05A, 1, 0, 0, 1);
    do_read();
    chk_state("R7", 9'h05A, 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 0, 1, -1);
    send_frame(9'h022, 0, 1, -1);
    chk_state("R6", 9'h011, 1, 0, 1, 0);
    do_read();
    chk_state("R7", 9'h011, 0, 0, 0, 0);
  endtask

  task automatic t_break_ovr();
    send_frame(9'h033, 0, 1, -1);
    send_frame(9'h000, 0, 0, -1);
    chk_state("R10", 9'h033, 1, 0, 1, 0);
    do_read();
  endtask

  task automatic t_false();
    for (int i = 0; i < 3; i++) slot(1'b0);
    for (int i = 0; i < 48; i++) slot(1'b1);
    chk(rx_full === 1'b0, "R9 no frame posted", 16'(rx_full), 16'h0);
    send_frame(9'h0C6, 0, 1, -1);
    chk_state("R9 recovers", 9'h0C6, 1, 0, 0, 0);
    do_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    for (int i = 0; i < 4; i++) slot(1'b1);
    t_basic8();
    t_nine();
    t_ferr();
    t_break8();
    t_break9();
    t_noise();
    t_overrun();
    t_break_ovr();
    t_false();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule